// File: doc/BRIEF.md
# Wait-State Controller with Early-Address Detection

This block paces every bus cycle of a processor-style bus. The processor marks the start of a cycle by pulling an active-low address strobe. An external decoder drives two chip selects, one for memory and one for I/O. The block turns the selected device class into a wait-state count. It holds the bus-busy state and returns an active-low ready for one clock when the count has run out.

The processor may present the next address before the current cycle has finished. The block sees this as a strobe sampled while the bus is busy. It stores the class of that early cycle, and the stored cycle takes one wait state less than a normal cycle of the same class. That cycle starts on the edge where the current ready is taken. The bus-busy state does not drop across that edge.

All inputs are sampled on the rising clock edge, and both outputs are registered. Time is counted from T0, the rising edge at which a cycle begins. For a normal cycle, T0 is the edge where the strobe is sampled. For an early cycle, T0 is the edge where the previous cycle's ready is sampled. With a count of N, ready is low in the clock that follows edge T0+N, so the processor samples it at edge T0+N+1. The cycle ends at that edge. These pins are plain control signals, with no valid/ready handshake and no back-pressure.

Top module: `wsc_ctrl`

## Requirements
- R1: A memory cycle that starts from an idle bus inserts one wait state: rdy_n is low only in the clock after edge T0+1.
- R2: An I/O cycle that starts from an idle bus inserts four wait states: rdy_n is low only in the clock after edge T0+4.
- R3: An early cycle uses one wait state less than its class. A memory cycle has zero, so rdy_n is low right after its T0. An I/O cycle has three, so rdy_n is low after T0+3. In both cases T0 is the edge where the previous ready is sampled.
- R4: A strobe sampled while bus_idle is 0 marks an early cycle. Its class is stored, and bus_idle stays 0 from the first cycle through the end of the early cycle.
- R5: bus_idle is 1 when no cycle is outstanding. It goes to 0 on the edge that starts a cycle and returns to 1 on the edge where the last ready is sampled. rdy_n is never low while bus_idle is 1.
- R6: Each cycle drives rdy_n low for exactly one clock. At all other times rdy_n is 1.
- R7: The select decode works as follows. cs_io=1 selects the I/O count, whatever cs_mem is. cs_io=0 selects the memory count, including when both selects are 0.
- R8: A strobe sampled while an early cycle is already stored is ignored. No extra ready appears, and the bus goes idle after the stored cycle.
- R9: A synchronous reset (rst=1 at an edge) makes bus_idle 1 and rdy_n 1. It also clears any stored cycle and the wait counter, so no ready follows from a cycle begun before the reset.
- R10: A strobe sampled on the same edge as a ready, with nothing stored, starts an early cycle at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| cs_mem | input | 1 | Memory select from the address decoder |
| cs_io | input | 1 | I/O select from the address decoder; has priority |
| rdy_n | output | 1 | Cycle-complete ready, active low, one clock per cycle |
| bus_idle | output | 1 | High when no bus cycle is outstanding |

## Verification
The hardest states to reach are those where a second strobe lands inside a busy window. This can be the edge where ready is sampled, or an edge after an early cycle has already been stored. The bench reaches them by driving strobes at chosen clock offsets from the first cycle's start, counted in falling edges. It then checks, clock by clock, where each ready pulse falls and when the bus goes idle. A reset issued mid-cycle shows that the stored work is dropped.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef struct packed {
    logic is_io;
    logic early;
  } wsc_req_t;

  function automatic int unsigned wsc_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned wsc_minus_one(input int unsigned a);
    return (a > 0) ? a - 1 : 0;
  endfunction

endpackage

// File: rtl/wsc_wait_sel.sv
module wsc_wait_sel
  import wsc_pkg::*;
#(
  parameter int unsigned MEM_WAITS = 1,
  parameter int unsigned IO_WAITS  = 4,
  parameter int unsigned CNT_W     = 3
) (
  input  wsc_req_t         req,
  output logic [CNT_W-1:0] waits
);
  localparam logic [CNT_W-1:0] MEM_FULL  = CNT_W'(MEM_WAITS);
  localparam logic [CNT_W-1:0] IO_FULL   = CNT_W'(IO_WAITS);
  localparam logic [CNT_W-1:0] MEM_SHORT = CNT_W'(wsc_minus_one(MEM_WAITS));
  localparam logic [CNT_W-1:0] IO_SHORT  = CNT_W'(wsc_minus_one(IO_WAITS));

  always_comb begin
    unique case ({req.is_io, req.early})
      2'b00:   waits = MEM_FULL;
      2'b01:   waits = MEM_SHORT;
      2'b10:   waits = IO_FULL;
      default: waits = IO_SHORT;
    endcase
  end
endmodule

// File: rtl/wsc_pend_slot.sv
module wsc_pend_slot
  import wsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     capture,
  input  logic     release_i,
  input  wsc_req_t req_in,
  output wsc_req_t req_out,
  output logic     valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      req_out <= '0;
    end else if (release_i) begin
      valid   <= 1'b0;
    end else if (capture) begin
      valid   <= 1'b1;
      req_out <= req_in;
    end
  end
endmodule

// File: rtl/wsc_cycle_timer.sv
module wsc_cycle_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             go_idle,
  input  logic [CNT_W-1:0] load,
  output logic             rdy_n,
  output logic             bus_idle
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      rdy_n    <= 1'b1;
      bus_idle <= 1'b1;
    end else if (start) begin
      bus_idle <= 1'b0;
      remain   <= load;
      rdy_n    <= (load != '0);
    end else if (go_idle) begin
      bus_idle <= 1'b1;
      rdy_n    <= 1'b1;
      remain   <= '0;
    end else if (!bus_idle) begin
      if (remain == CNT_W'(1)) rdy_n <= 1'b0;
      if (remain != '0) remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wsc_ctrl.sv
module wsc_ctrl
  import wsc_pkg::*;
#(
  parameter int unsigned MEM_WAITS = 1,
  parameter int unsigned IO_WAITS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ads_n,
  input  logic cs_mem,
  input  logic cs_io,
  output logic rdy_n,
  output logic bus_idle
);
  localparam int unsigned MAX_WAITS = wsc_max(MEM_WAITS, IO_WAITS);
  localparam int unsigned CNT_W     = (MAX_WAITS < 2) ? 1 : $clog2(MAX_WAITS + 1);

  logic             strobe;
  logic             end_edge;
  logic             from_idle;
  logic             start;
  logic             go_idle;
  logic             capture;
  logic             pend_valid;
  logic             sel_io;
  wsc_req_t         pend_req;
  wsc_req_t         now_req;
  wsc_req_t         start_req;
  logic [CNT_W-1:0] waits;

  // I/O select wins; no select at all falls back to memory timing
  always_comb begin
    unique case ({cs_io, cs_mem})
      2'b10, 2'b11: sel_io = 1'b1;
      2'b01:        sel_io = 1'b0;
      default:      sel_io = 1'b0;
    endcase
  end

  assign strobe    = !ads_n;
  assign end_edge  = !bus_idle && !rdy_n;
  assign from_idle = bus_idle && strobe;
  assign now_req   = '{is_io: sel_io, early: !bus_idle};
  assign capture   = !bus_idle && !end_edge && strobe && !pend_valid;
  assign start     = from_idle || (end_edge && (pend_valid || strobe));
  assign go_idle   = end_edge && !start;

  always_comb begin
    if (end_edge && pend_valid) start_req = pend_req;
    else                        start_req = now_req;
  end

  wsc_pend_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .release_i (end_edge),
    .req_in    (now_req),
    .req_out   (pend_req),
    .valid     (pend_valid)
  );

  wsc_wait_sel #(
    .MEM_WAITS (MEM_WAITS),
    .IO_WAITS  (IO_WAITS),
    .CNT_W     (CNT_W)
  ) u_sel (
    .req   (start_req),
    .waits (waits)
  );

  wsc_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .go_idle  (go_idle),
    .load     (waits),
    .rdy_n    (rdy_n),
    .bus_idle (bus_idle)
  );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int unsigned MEM_WAITS = 1,
  parameter int unsigned IO_WAITS  = 4
) (
  input logic clk,
  input logic rst,
  input logic ads_n,
  input logic cs_io,
  input logic rdy_n,
  input logic bus_idle,
  input logic pend_valid
);
  // R5: no ready while the bus is idle
  a_r5_no_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> !bus_idle);

  // R5: a strobe on an idle bus makes it busy
  a_r5_idle_start: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && !ads_n) |=> !bus_idle);

  // R4: an early strobe keeps the bus busy
  a_r4_early_keeps_busy: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && rdy_n && !ads_n) |=> !bus_idle);

  // R9: reset state
  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (bus_idle && rdy_n && !pend_valid));

  // R6: a ready never repeats unless a new cycle was waiting
  a_r6_single_ready: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n && !pend_valid && ads_n) |=> rdy_n);

  if (MEM_WAITS == 1) begin : g_mem_one
    // R1: memory cycle from idle, one wait state
    a_r1_mem_one_wait: assert property (@(posedge clk) disable iff (rst)
      (bus_idle && !ads_n && !cs_io) |=> rdy_n ##1 !rdy_n);
    // R3 and R10: early memory cycle, zero wait states
    a_r3_early_mem_zero: assert property (@(posedge clk) disable iff (rst)
      (!bus_idle && !rdy_n && !pend_valid && !ads_n && !cs_io) |=> !rdy_n);
  end
endmodule

bind wsc_ctrl wsc_checker #(
  .MEM_WAITS (MEM_WAITS),
  .IO_WAITS  (IO_WAITS)
) u_wsc_checker (
  .clk        (clk),
  .rst        (rst),
  .ads_n      (ads_n),
  .cs_io      (cs_io),
  .rdy_n      (rdy_n),
  .bus_idle   (bus_idle),
  .pend_valid (pend_valid)
);

// File: tb/test_wsc_ctrl.sv
`timescale 1ns/1ps
module test_wsc_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ads_n = 1'b1;
  logic cs_mem = 1'b0;
  logic cs_io = 1'b0;
  logic rdy_n;
  logic bus_idle;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wsc_ctrl i_wsc_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ads_n    (ads_n),
    .cs_mem   (cs_mem),
    .cs_io    (cs_io),
    .rdy_n    (rdy_n),
    .bus_idle (bus_idle)
  );

  task automatic check_bit(input string req, input string what, input int k,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at k=%0d: actual=%b expected=%b", req, what, k, act, exp);
    end
  endtask

  // Start a cycle at edge T0; at falling edge k (after edge T0+k) check outputs,
  // then optionally drive a strobe to be sampled at edge T0+k+1.
  task automatic run_case(input string req, input bit m0, input bit i0,
                          input int ka, input bit ma, input bit ia,
                          input int kb, input bit mb, input bit ib,
                          input int low1, input int low2, input int idle_k,
                          input int span);
    @(negedge clk);
    ads_n = 1'b0; cs_mem = m0; cs_io = i0;
    @(posedge clk);
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      check_bit(req, "rdy_n", k, rdy_n, (k == low1 || k == low2) ? 1'b0 : 1'b1);
      check_bit(req, "bus_idle", k, bus_idle, (k < idle_k) ? 1'b0 : 1'b1);
      if (k == ka) begin
        ads_n = 1'b0; cs_mem = ma; cs_io = ia;
      end else if (k == kb) begin
        ads_n = 1'b0; cs_mem = mb; cs_io = ib;
      end else begin
        ads_n = 1'b1; cs_mem = 1'b0; cs_io = 1'b0;
      end
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check_bit("R9", "bus_idle", -1, bus_idle, 1'b1);
    check_bit("R9", "rdy_n", -1, rdy_n, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_mem_plain;
    run_case("R1", 1, 0, -1, 0, 0, -1, 0, 0, 1, -1, 2, 6);
  endtask

  task automatic t_io_plain;
    run_case("R2", 0, 1, -1, 0, 0, -1, 0, 0, 4, -1, 5, 8);
  endtask

  task automatic t_early_mem_after_io;
    run_case("R3 R4", 0, 1, 1, 1, 0, -1, 0, 0, 4, 5, 6, 9);
  endtask

  task automatic t_early_io_after_mem;
    run_case("R3 R4", 1, 0, 0, 0, 1, -1, 0, 0, 1, 5, 6, 9);
  endtask

  task automatic t_decode;
    run_case("R7 none", 0, 0, -1, 0, 0, -1, 0, 0, 1, -1, 2, 5);
    run_case("R7 both", 1, 1, -1, 0, 0, -1, 0, 0, 4, -1, 5, 8);
  endtask

  task automatic t_strobe_on_ready;
    run_case("R10", 1, 0, 1, 1, 0, -1, 0, 0, 1, 2, 3, 6);
  endtask

  task automatic t_extra_strobe;
    run_case("R8", 0, 1, 0, 1, 0, 1, 0, 1, 4, 5, 6, 13);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    ads_n = 1'b0; cs_mem = 1'b0; cs_io = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ads_n = 1'b1; cs_io = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check_bit("R9", "rdy_n", k, rdy_n, 1'b1);
      check_bit("R9", "bus_idle", k, bus_idle, 1'b1);
      @(negedge clk);
    end
    run_case("R9 after", 1, 0, -1, 0, 0, -1, 0, 0, 1, -1, 2, 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    t_mem_plain();
    t_io_plain();
    t_early_mem_after_io();
    t_early_io_after_mem();
    t_decode();
    t_strobe_on_ready();
    t_extra_strobe();
    t_reset_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule